// File: doc/BRIEF.md
# Diagnostic Event Counter Bank

This block keeps a small bank of diagnostic event counters and the control word that starts them and zeroes them. Other logic in the system sends it single-cycle event pulses, such as a pulse for each packet header found to be in error. Each pulse goes to that counter's own input. A host reads the counters and drives the control word through a plain register bus. The bus has a byte address, 32-bit write data, byte strobes and a combinational read path.

The two control bits are commands, not stored settings.
- Setting the start bit turns counting on.
- Setting the zeroing bit alone turns counting off and sets every counter to zero in the same clock edge.
- A zeroing request that comes with the start bit is refused.
- A write that does not strobe both of the low two bytes is not acted on. The bits it wrote stay visible on readback until a full control write arrives.

Each counter is 12 bits wide. It stops at its maximum value instead of wrapping, and it reads back zero-extended to 16 bits.

Top module: `evc_bank`

## Requirements
- R1: After a synchronous active-low reset, counting is off, every counter reads zero and the control word reads zero.
- R2: While counting is off, event pulses leave every counter unchanged.
- R3: While counting is on, each event pulse present at a rising clock edge adds one to that input's counter, and the new value is readable after that edge.
- R4: A counter at 4095 stays at 4095 on further pulses. Bits 31..12 of a counter read are always zero.
- R5: An accepted control write with bit 0 = 1 turns counting on. An accepted control write with bit 1 = 1 and bit 0 = 0 turns counting off and zeroes all counters.
- R6: An accepted control write with both bit 0 and bit 1 set performs no zeroing and leaves counting on.
- R7: After an accepted control write, control bits 1..0 read as zero. Bits 31..2 of the control word always read as zero.
- R8: A write to offset 0x00 is accepted only if byte strobes 0 and 1 are both set. A write that strobes byte 0 without byte 1 changes neither the counting state nor the counters, and its bits 1..0 are read back from offset 0x00.
- R9: If an accepted zeroing write and an event pulse fall in the same cycle, the counter ends at zero.
- R10: Counter i is read at byte offset 0x04 + 2*i (0x04, 0x06, 0x08, 0x0A), in bits 15..0. Writes to these offsets change nothing, and any unmapped offset reads zero.
- R11: An accepted control write of 0x00 does not turn counting off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte strobes of the write |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| events | input | NUM_CNT (4) | One event pulse per counter |

## Verification
Every state change lands on the rising edge that ends the cycle in which the write or pulse was presented. Read data follows the address within that same cycle, so a result becomes visible one edge after its stimulus. The bench changes inputs on the falling edge and samples read data just after the next falling edge. By then exactly one rising edge has passed, and the value read is the state after that edge. Saturation is reached by a run of pulses one cycle apart. The collision case presents the zeroing write and the pulse in the same cycle, so both act on the same edge.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int CTRL_OFS = 0;
  localparam int CNT_BASE = 4;
  localparam int CNT_STEP = 2;
  localparam int RD_W     = 16;

  // next value of a counter that holds at its top value
  function automatic logic [31:0] sat_step(logic [31:0] v, logic [31:0] top);
    return (v == top) ? v : v + 32'd1;
  endfunction

  // a control write acts only when both low byte lanes are strobed
  function automatic logic covers_low(logic [3:0] be);
    return be[0] & be[1];
  endfunction

  function automatic int cnt_offset(int idx);
    return CNT_BASE + CNT_STEP * idx;
  endfunction
endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wbits,
  input  logic [3:0]        be,
  output logic              en_q,
  output logic              clr_acc,
  output logic              ctrl_acc,
  output logic [1:0]        ctrl_hold
);
  logic hit;
  logic part;

  assign hit      = wr && (addr == ADDR_W'(CTRL_OFS));
  assign ctrl_acc = hit && covers_low(be);
  assign part     = hit && be[0] && !be[1];
  // zeroing only when the start bit is not requested alongside
  assign clr_acc  = ctrl_acc && wbits[1] && !wbits[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      ctrl_hold <= 2'b00;
    end else begin
      if (ctrl_acc) begin
        if (wbits[0])      en_q <= 1'b1;
        else if (wbits[1]) en_q <= 1'b0;
      end
      if (ctrl_acc)  ctrl_hold <= 2'b00;
      else if (part) ctrl_hold <= wbits;
    end
  end
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [31:0] TOP = 32'((64'd1 << CNT_W) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= CNT_W'(sat_step(32'(cnt), TOP));
  end
endmodule

// File: rtl/evc_rdmux.sv
module evc_rdmux
  import evc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 12
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [1:0]               ctrl_hold,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic [31:0]              rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_OFS)) rdata = {30'b0, ctrl_hold};
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr == ADDR_W'(cnt_offset(i)))
        rdata = {{(32-RD_W){1'b0}}, RD_W'(cnt_flat[i*CNT_W +: CNT_W])};
    end
  end
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [3:0]         reg_be,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_CNT-1:0] events
);
  localparam int FLAT_W = NUM_CNT * CNT_W;

  logic              en_q;
  logic              clr_acc;
  logic              ctrl_acc;
  logic [1:0]        ctrl_hold;
  logic [FLAT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0] cnt_inc;
  logic              unused_bits;

  // reserved data bits and upper byte lanes carry no function
  assign unused_bits = ^{reg_wdata[31:2], reg_be[3:2]};

  evc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wbits(reg_wdata[1:0]), .be(reg_be), .en_q(en_q),
    .clr_acc(clr_acc), .ctrl_acc(ctrl_acc), .ctrl_hold(ctrl_hold)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cnt_inc[g] = en_q && events[g];
    evc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_acc), .inc(cnt_inc[g]),
      .cnt(cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  evc_rdmux #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rd (
    .addr(reg_addr), .ctrl_hold(ctrl_hold), .cnt_flat(cnt_flat),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en_q,
  input logic                     clr_acc,
  input logic                     ctrl_acc,
  input logic [1:0]               ctrl_hold,
  input logic                     wbit0,
  input logic [NUM_CNT-1:0]       events,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic [CNT_W-1:0] c0;
  assign c0 = cnt_flat[CNT_W-1:0];

  assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_acc) |=> $stable(cnt_flat));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && events[0] && !clr_acc && c0 != TOP) |=> (c0 == $past(c0) + 1'b1));

  assert_hold_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c0 == TOP && !clr_acc) |=> (c0 == TOP));

  assert_zero_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (cnt_flat == '0 && !en_q));

  assert_no_clear_with_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_acc && wbit0 && en_q && events == '0) |=> ($stable(cnt_flat) && en_q));

  assert_bits_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc |=> (ctrl_hold == 2'b00));
endmodule

bind evc_bank evc_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .clr_acc(clr_acc),
  .ctrl_acc(ctrl_acc), .ctrl_hold(ctrl_hold), .wbit0(reg_wdata[0]),
  .events(events), .cnt_flat(cnt_flat)
);

// File: tb/tb_evc_bank.sv
module tb_evc_bank;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  events = '0;
  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #(CLK_P/2) clk = ~clk;

  evc_bank dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata), .events(events));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      events = m;
    end
    @(negedge clk);
    events = '0;
  endtask

  task automatic chk_counts(input string tag, input int e0, input int e1, input int e2, input int e3);
    rd(8'h04, v); chk({tag, " cnt0"}, v, 32'(e0));
    rd(8'h06, v); chk({tag, " cnt1"}, v, 32'(e1));
    rd(8'h08, v); chk({tag, " cnt2"}, v, 32'(e2));
    rd(8'h0A, v); chk({tag, " cnt3"}, v, 32'(e3));
  endtask

  task automatic t_reset_and_off;
    chk_counts("R1 reset", 0, 0, 0, 0);
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    pulse(4'hF, 3);
    chk_counts("R2 off", 0, 0, 0, 0);
  endtask

  task automatic t_count;
    wr(8'h00, 32'h0000_0001, 4'b0011);
    rd(8'h00, v); chk("R7 ctrl after start", v, 32'h0);
    pulse(4'b0001, 3);
    pulse(4'b0010, 1);
    pulse(4'b1001, 2);
    chk_counts("R3 count", 5, 1, 0, 2);
  endtask

  task automatic t_zero_write;
    wr(8'h00, 32'h0, 4'b1111);
    pulse(4'b0100, 1);
    chk_counts("R11 zero write", 5, 1, 1, 2);
  endtask

  task automatic t_start_with_clear;
    wr(8'h00, 32'hFFFF_FFFF, 4'b1111);
    rd(8'h00, v); chk("R7 reserved read zero", v, 32'h0);
    chk_counts("R6 no clear", 5, 1, 1, 2);
    pulse(4'b0001, 1);
    rd(8'h04, v); chk("R6 still counting", v, 32'd6);
  endtask

  task automatic t_partial;
    wr(8'h00, 32'h0000_0002, 4'b0001);
    rd(8'h00, v); chk("R8 held bits", v, 32'h2);
    chk_counts("R8 no clear", 6, 1, 1, 2);
    pulse(4'b0010, 1);
    rd(8'h06, v); chk("R8 still counting", v, 32'd2);
    wr(8'h00, 32'h0000_0001, 4'b0011);
    rd(8'h00, v); chk("R7 held bits cleared", v, 32'h0);
  endtask

  task automatic t_clear_restart;
    wr(8'h00, 32'h0000_0002, 4'b0011);
    chk_counts("R5 cleared", 0, 0, 0, 0);
    pulse(4'hF, 2);
    chk_counts("R5 stopped", 0, 0, 0, 0);
    wr(8'h00, 32'h0000_0001, 4'b0011);
    pulse(4'b1000, 2);
    chk_counts("R5 restarted", 0, 0, 0, 2);
  endtask

  task automatic t_collide;
    pulse(4'b0001, 1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h2; reg_be = 4'b0011; events = 4'b0001;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0; events = '0;
    chk_counts("R9 clear wins", 0, 0, 0, 0);
  endtask

  task automatic t_saturate;
    wr(8'h00, 32'h0000_0001, 4'b0011);
    pulse(4'b0100, 4100);
    rd(8'h08, v); chk("R4 saturate", v, 32'd4095);
    pulse(4'b0100, 1);
    rd(8'h08, v); chk("R4 held top", v, 32'd4095);
  endtask

  task automatic t_map;
    wr(8'h04, 32'hFFFF_FFFF, 4'b1111);
    wr(8'h08, 32'h0000_0000, 4'b1111);
    chk_counts("R10 write ignored", 0, 0, 4095, 0);
    rd(8'h0C, v); chk("R10 unmapped 0C", v, 32'h0);
    rd(8'h02, v); chk("R10 unmapped 02", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_off();
    t_count();
    t_zero_write();
    t_start_with_clear();
    t_partial();
    t_clear_restart();
    t_collide();
    t_saturate();
    t_map();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule